// File: doc/BRIEF.md
# Indexed Bit-Manipulation Executor

This block runs the rotate, shift and single-bit instructions of an 8-bit processor. These instructions address their memory operand through a 16-bit index register plus a signed 8-bit offset. The sequencer that fetched the prefixes hands over the index value, the offset, the final opcode byte, the current flag byte and the current refresh counter, and pulses `start`. The block then forms the operand address and reads the byte through a port with one cycle of latency. It decodes the opcode into a group and computes the new value and flags. It ends with a single `done` cycle.

In that `done` cycle, a modifying operation drives the memory write port with the result at the same address. If the opcode's low register field does not name the memory slot, it also drives the register write port with that result. During the same cycle the block presents the updated flags, the cycle cost and the memory-pointer value. It also presents the refresh counter with one count taken off. These outputs stay valid until the next operation finishes.

Top module: `idx_bitop_exec`

## Requirements
- R1: The operand address is `idx_base` plus `disp` taken as a two's-complement value, truncated to 16 bits. It is driven on `mem_addr` in the cycle that `mem_rd_en` is high.
- R2: After each operation, `memptr` holds the operand address, and `mem_addr` equals it while the write port is active.
- R3: Opcode bits 7:6 choose the group: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. Each group except bit test asserts `mem_wr_en` for exactly the `done` cycle, writing `mem_wr_data` to the operand address.
- R4: Opcode bits 2:0 are the register code (0..5 and 7 name a register; 6 names memory only). A modifying operation with a code other than 6 asserts `reg_wr_en` in the `done` cycle, with `reg_wr_sel` equal to the code and `reg_wr_data` equal to the result. Code 6 leaves `reg_wr_en` low.
- R5: For rotate/shift, opcode bits 5:3 choose the operation: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic left, 5 arithmetic right (sign kept), 6 left with a 1 inserted at bit 0, 7 logical right.
- R6: The flag byte is laid out S=7, Z=6, bit5, H=4, bit3, P/V=2, N=1, C=0. After rotate/shift, C holds the bit moved out. S, Z and P/V (set on even parity) follow the result, H=N=0, and bits 5 and 3 copy the result.
- R7: A bit test of bit n (opcode bits 5:3) sets Z and P/V when that bit is 0. It sets H, clears N and keeps C. S is set only for n=7 with the bit at 1. Flag bits 5 and 3 take address bits 13 and 11.
- R8: A bit test performs no memory or register write and reports 20 cycles. Every other opcode reports 23.
- R9: Bit clear and bit set force bit n of the operand to 0 or 1 and leave the flag byte unchanged.
- R10: `refresh_out` is `refresh_in` with its low 7 bits decremented modulo 128 and bit 7 kept.
- R11: After reset, `done`, `mem_wr_en` and `reg_wr_en` are low and `memptr` is 0. `mem_rd_en` rises the cycle after `start` is sampled, `done` comes two cycles after that, and `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| idx_base | input | 16 | Index register value |
| disp | input | 8 | Signed address offset |
| opcode | input | 8 | Final opcode byte |
| flags_in | input | 8 | Flag byte before the operation |
| refresh_in | input | 8 | Refresh counter before the operation |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory address for read and write |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 8 | Memory write data |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_sel | output | 3 | Register code of the write |
| reg_wr_data | output | 8 | Register write data |
| done | output | 1 | Operation finished (one cycle) |
| cycles_out | output | 5 | Cycle cost of the last operation |
| memptr | output | 16 | Memory-pointer value after the last operation |
| flags_out | output | 8 | Flag byte after the last operation |
| refresh_out | output | 8 | Refresh counter after the last operation |

## Verification
The bench runs all 256 opcodes in four passes. Each pass uses a different index, offset, flag byte, refresh value and operand set. The passes cover an address that wraps past 0xFFFF, a negative offset that wraps below zero, and a refresh value whose low bits underflow. A wrong sign extension or a missing wrap would show up as a bad read address or `memptr`. A missing carry-in on the through-carry rotates, a lost sign bit on the arithmetic right shift, or a 0 instead of a 1 inserted by the left-with-one shift would each corrupt the written byte and the C flag. Taking bit-test bits 5 and 3 from the operand instead of the address, or writing back on a bit test or on register code 6, would be caught by the flag and strobe comparisons.

// File: rtl/idx_bitop_pkg.sv
package idx_bitop_pkg;

    localparam int DW     = 8;
    localparam int CYC_W  = 5;
    localparam logic [CYC_W-1:0] CYC_TEST   = 5'd20;
    localparam logic [CYC_W-1:0] CYC_MODIFY = 5'd23;
    localparam logic [2:0]       REG_CODE_MEM = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLEAR = 2'b10,
        GRP_SETB  = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC, SH_RRC, SH_RL, SH_RR, SH_SLA, SH_SRA, SH_SL1, SH_SRL
    } shop_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_READ, ST_EXEC, ST_DONE
    } state_e;

    // bit 7 first: sign, zero, copy5, half, copy3, parity, subtract, carry
    typedef struct packed {
        logic s;
        logic z;
        logic y;
        logic h;
        logic x;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] sel;
        logic [2:0] dst;
    } op_fields_t;

    typedef struct packed {
        logic [DW-1:0]    data;
        flags_t           flg;
        logic             wr_mem;
        logic             wr_reg;
        logic [CYC_W-1:0] cyc;
    } alu_out_t;

    // returns {carry_out, result}
    function automatic logic [DW:0] shift_op(shop_e op, logic [DW-1:0] v, logic cin);
        logic [DW:0] r;
        case (op)
            SH_RLC:  r = {v[DW-1], v[DW-2:0], v[DW-1]};
            SH_RRC:  r = {v[0], v[0], v[DW-1:1]};
            SH_RL:   r = {v[DW-1], v[DW-2:0], cin};
            SH_RR:   r = {v[0], cin, v[DW-1:1]};
            SH_SLA:  r = {v[DW-1], v[DW-2:0], 1'b0};
            SH_SRA:  r = {v[0], v[DW-1], v[DW-1:1]};
            SH_SL1:  r = {v[DW-1], v[DW-2:0], 1'b1};
            default: r = {v[0], 1'b0, v[DW-1:1]};
        endcase
        return r;
    endfunction

    function automatic logic even_parity(logic [DW-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/idx_ea_calc.sv
module idx_ea_calc #(
    parameter int AW   = 16,
    parameter int OFSW = 8
) (
    input  logic [AW-1:0]   base,
    input  logic [OFSW-1:0] ofs,
    output logic [AW-1:0]   ea
);
    localparam int EXT_W = AW - OFSW;

    logic [AW-1:0] ofs_ext;

    assign ofs_ext = {{EXT_W{ofs[OFSW-1]}}, ofs};
    assign ea      = base + ofs_ext;
endmodule

// File: rtl/idx_bitop_alu.sv
module idx_bitop_alu
    import idx_bitop_pkg::*;
(
    input  logic [DW-1:0] opcode,
    input  logic [DW-1:0] operand,
    input  flags_t        flags_in,
    input  logic [1:0]    addr_hint,   // {address bit 13, address bit 11}
    output alu_out_t      res
);
    op_fields_t  f;
    logic [DW:0] sh;
    logic        tbit;
    logic [DW-1:0] mask;

    always_comb begin
        f    = op_fields_t'(opcode);
        sh   = shift_op(shop_e'(f.sel), operand, flags_in.c);
        tbit = operand[f.sel];
        mask = 8'd1 << f.sel;

        res        = '0;
        res.flg    = flags_in;
        res.data   = operand;
        res.cyc    = CYC_MODIFY;
        res.wr_mem = 1'b1;
        res.wr_reg = (f.dst != REG_CODE_MEM);

        case (f.grp)
            GRP_SHIFT: begin
                res.data   = sh[DW-1:0];
                res.flg.s  = sh[DW-1];
                res.flg.z  = (sh[DW-1:0] == '0);
                res.flg.y  = sh[5];
                res.flg.h  = 1'b0;
                res.flg.x  = sh[3];
                res.flg.pv = even_parity(sh[DW-1:0]);
                res.flg.n  = 1'b0;
                res.flg.c  = sh[DW];
            end
            GRP_TEST: begin
                res.wr_mem = 1'b0;
                res.wr_reg = 1'b0;
                res.cyc    = CYC_TEST;
                res.flg.s  = (f.sel == 3'd7) && tbit;
                res.flg.z  = ~tbit;
                res.flg.y  = addr_hint[1];
                res.flg.h  = 1'b1;
                res.flg.x  = addr_hint[0];
                res.flg.pv = ~tbit;
                res.flg.n  = 1'b0;
            end
            GRP_CLEAR: res.data = operand & ~mask;
            default:   res.data = operand | mask;
        endcase
    end
endmodule

// File: rtl/idx_bitop_ctrl.sv
module idx_bitop_ctrl
    import idx_bitop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic rd_en,
    output logic exec,
    output logic fin
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_READ;
            ST_READ: state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign load  = (state_q == ST_IDLE) && start;
    assign rd_en = (state_q == ST_READ);
    assign exec  = (state_q == ST_EXEC);
    assign fin   = (state_q == ST_DONE);
endmodule

// File: rtl/idx_bitop_exec.sv
module idx_bitop_exec
    import idx_bitop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] idx_base,
    input  logic [7:0]        disp,
    input  logic [7:0]        opcode,
    input  logic [7:0]        flags_in,
    input  logic [7:0]        refresh_in,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wr_data,
    output logic              reg_wr_en,
    output logic [2:0]        reg_wr_sel,
    output logic [7:0]        reg_wr_data,
    output logic              done,
    output logic [4:0]        cycles_out,
    output logic [ADDR_W-1:0] memptr,
    output logic [7:0]        flags_out,
    output logic [7:0]        refresh_out
);
    localparam int HINT_HI = ADDR_W - 3;
    localparam int HINT_LO = ADDR_W - 5;

    logic              load, exec, fin;
    logic [ADDR_W-1:0] base_q;
    logic [7:0]        disp_q, op_q, ref_q;
    flags_t            flg_q;
    logic [ADDR_W-1:0] ea;
    alu_out_t          alu_res, res_q;

    idx_bitop_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .rd_en (mem_rd_en),
        .exec  (exec),
        .fin   (fin)
    );

    idx_ea_calc #(.AW(ADDR_W), .OFSW(8)) u_ea (
        .base (base_q),
        .ofs  (disp_q),
        .ea   (ea)
    );

    idx_bitop_alu u_alu (
        .opcode    (op_q),
        .operand   (mem_rd_data),
        .flags_in  (flg_q),
        .addr_hint ({ea[HINT_HI], ea[HINT_LO]}),
        .res       (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            disp_q <= '0;
            op_q   <= '0;
            ref_q  <= '0;
            flg_q  <= '0;
        end else if (load) begin
            base_q <= idx_base;
            disp_q <= disp;
            op_q   <= opcode;
            ref_q  <= refresh_in;
            flg_q  <= flags_t'(flags_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q       <= '0;
            memptr      <= '0;
            refresh_out <= '0;
        end else if (exec) begin
            res_q       <= alu_res;
            memptr      <= ea;
            refresh_out <= {ref_q[7], ref_q[6:0] - 7'd1};
        end
    end

    assign mem_addr    = ea;
    assign done        = fin;
    assign mem_wr_en   = fin && res_q.wr_mem;
    assign mem_wr_data = res_q.data;
    assign reg_wr_en   = fin && res_q.wr_reg;
    assign reg_wr_sel  = op_q[2:0];
    assign reg_wr_data = res_q.data;
    assign cycles_out  = res_q.cyc;
    assign flags_out   = res_q.flg;
endmodule

// File: rtl/idx_bitop_chk.sv
module idx_bitop_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              reg_wr_en,
    input logic [2:0]        reg_wr_sel,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] memptr,
    input logic [4:0]        cycles_out
);
    AST_WR_ADDR_IS_PTR: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_addr == memptr);                          // R2
    AST_WR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> done);                                        // R3
    AST_REG_NOT_MEMSLOT: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (mem_wr_en && reg_wr_sel != 3'd6));           // R4
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done && cycles_out == 5'd20) |-> (!mem_wr_en && !reg_wr_en)); // R8
    AST_CYCLES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles_out == 5'd20 || cycles_out == 5'd23));    // R8
    AST_READ_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> ##2 done);                                    // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R11
endmodule

bind idx_bitop_exec idx_bitop_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/idx_bitop_exec_tb.sv
module idx_bitop_exec_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] idx_base;
    logic [7:0]  disp, opcode, flags_in, refresh_in;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [7:0]  mem_wr_data;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_sel;
    logic [7:0]  reg_wr_data;
    logic        done;
    logic [4:0]  cycles_out;
    logic [15:0] memptr;
    logic [7:0]  flags_out, refresh_out;
    logic [7:0]  mem_val;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val;

    idx_bitop_exec u_dut (
        .clk(clk), .rst(rst), .start(start), .idx_base(idx_base), .disp(disp),
        .opcode(opcode), .flags_in(flags_in), .refresh_in(refresh_in),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .done(done), .cycles_out(cycles_out), .memptr(memptr),
        .flags_out(flags_out), .refresh_out(refresh_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pick_val(input int k);
        case (k % 8)
            0: return 8'h00;
            1: return 8'h80;
            2: return 8'h01;
            3: return 8'hFF;
            4: return 8'h55;
            5: return 8'hAA;
            6: return 8'h28;
            default: return 8'h96;
        endcase
    endfunction

    // independent arithmetic reference
    task automatic model(input logic [7:0] op, input logic [7:0] v, input logic [7:0] f,
                         input logic [15:0] ea, output logic [7:0] r, output logic [7:0] fo,
                         output logic wm, output logic wr, output logic [4:0] cyc);
        int s = int'(op[5:3]);
        int vi = int'(v);
        int cin = int'(f[0]);
        int co = 0;
        int ri = 0;
        logic b;
        wm = 1'b1; wr = (op[2:0] != 3'd6); cyc = 5'd23; fo = f; r = v;
        case (op[7:6])
            2'd0: begin
                case (s)
                    0: begin co = vi / 128; ri = (vi * 2 + co) % 256; end
                    1: begin co = vi % 2;   ri = vi / 2 + co * 128; end
                    2: begin co = vi / 128; ri = (vi * 2 + cin) % 256; end
                    3: begin co = vi % 2;   ri = vi / 2 + cin * 128; end
                    4: begin co = vi / 128; ri = (vi * 2) % 256; end
                    5: begin co = vi % 2;   ri = vi / 2 + (vi / 128) * 128; end
                    6: begin co = vi / 128; ri = (vi * 2 + 1) % 256; end
                    default: begin co = vi % 2; ri = vi / 2; end
                endcase
                r = 8'(ri);
                fo = {r[7], r == 8'd0, r[5], 1'b0, r[3], ($countones(r) % 2) == 0, 1'b0, co != 0};
            end
            2'd1: begin
                b = v[s];
                wm = 1'b0; wr = 1'b0; cyc = 5'd20;
                fo = {(s == 7) && b, !b, ea[13], 1'b1, ea[11], !b, 1'b0, f[0]};
            end
            2'd2: r = v & ~(8'(1) << s);
            default: r = v | (8'(1) << s);
        endcase
    endtask

    task automatic run_op(input logic [15:0] b, input logic [7:0] d, input logic [7:0] op,
                          input logic [7:0] f, input logic [7:0] rf, input logic [7:0] v);
        logic [15:0] ea;
        logic [7:0]  r, fo;
        logic        wm, wr;
        logic [4:0]  cyc;
        string       rq_d, rq_f;
        ea = 16'((int'(b) + int'($signed(d)) + 65536) % 65536);
        model(op, v, f, ea, r, fo, wm, wr, cyc);
        case (op[7:6])
            2'd0: begin rq_d = "R5"; rq_f = "R6"; end
            2'd1: begin rq_d = "R8"; rq_f = "R7"; end
            default: begin rq_d = "R9"; rq_f = "R9"; end
        endcase
        idx_base = b; disp = d; opcode = op; flags_in = f; refresh_in = rf; mem_val = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 rd_en", 32'(mem_rd_en), 32'd1);
        chk("R1 read addr", 32'(mem_addr), 32'(ea));
        @(negedge clk);
        chk("R11 early done", 32'(done), 32'd0);
        @(negedge clk);
        chk("R11 done", 32'(done), 32'd1);
        chk("R2 memptr", 32'(memptr), 32'(ea));
        chk("R8 cycles", 32'(cycles_out), 32'(cyc));
        chk(rq_f, 32'(flags_out), 32'(fo));
        chk("R3 mem_wr_en", 32'(mem_wr_en), 32'(wm));
        if (wm) begin
            chk(rq_d, 32'(mem_wr_data), 32'(r));
            chk("R2 write addr", 32'(mem_addr), 32'(ea));
        end
        chk("R4 reg_wr_en", 32'(reg_wr_en), 32'(wr));
        if (wr) begin
            chk("R4 reg_wr_sel", 32'(reg_wr_sel), 32'(op[2:0]));
            chk("R4 reg_wr_data", 32'(reg_wr_data), 32'(r));
        end
        chk("R10 refresh", 32'(refresh_out), 32'({rf[7], 7'(int'(rf[6:0]) + 127)}));
        @(negedge clk);
        chk("R11 pulse", 32'(done), 32'd0);
        chk("R3 no late write", 32'(mem_wr_en), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [4];
        logic [7:0]  disps [4];
        logic [7:0]  flgs  [4];
        logic [7:0]  refs  [4];
        bases = '{16'h1234, 16'hFFF0, 16'h0008, 16'h7F7F};
        disps = '{8'h05, 8'h20, 8'h80, 8'hFF};
        flgs  = '{8'h00, 8'hFF, 8'h01, 8'hA5};
        refs  = '{8'h80, 8'h00, 8'h05, 8'hFF};
        rst = 1'b1; start = 1'b0; idx_base = '0; disp = '0; opcode = '0;
        flags_in = '0; refresh_in = '0; mem_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset done", 32'(done), 32'd0);
        chk("R11 reset mem_wr_en", 32'(mem_wr_en), 32'd0);
        chk("R11 reset reg_wr_en", 32'(reg_wr_en), 32'd0);
        chk("R11 reset memptr", 32'(memptr), 32'd0);
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 256; op++) begin
                run_op(bases[p], disps[p], 8'(op), flgs[p], refs[p], pick_val(op + p * 3 + op / 8));
            end
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule